// File: doc/BRIEF.md
# Programmable-Bandwidth Digital Phase-Locked Loop Core

This core supplies the building blocks of a first-order, all-digital phase-locked loop. Its loop filter is an up/down counter whose length is chosen by a 4-bit code. The counter emits a carry pulse when it wraps upward and a borrow pulse when it wraps downward. Those pulses steer an increment/decrement stage. The stage normally divides its own clock by two, and each pulse either inserts or deletes one half-cycle of its output. Two phase detectors are provided, each with its own output: an exclusive-OR type and an edge-triggered set/reset type.

To close a loop, the integrator feeds the stage output through an external divide-by-N counter to one detector's feedback input, applies the reference to the other input, and wires the chosen detector output back to the counter direction input. The length code may be rewritten while the loop runs. Short counters give wide bandwidth and fast capture. Long counters give a narrow bandwidth.

The whole core runs from one system clock. The K-clock and the I/D-clock arrive as single-cycle enable strobes. Reset is synchronous and active high.

Top module: `dpll_core`

## Requirements
- R1: With length code 0 the counter is disabled. It never emits a carry or a borrow, so the stage output toggles exactly once per I/D strobe.
- R2: While the count enable is low, the counter holds its value and emits no pulses, even when K strobes arrive.
- R3: For a length code c from 1 to 15, the counter has c+2 stages. With direction low, each K strobe adds one. A strobe at the top value (2^(c+2)-1) wraps the count to 0 and emits a carry lasting one clock. Code 1 therefore gives modulus 8.
- R4: With direction high, each K strobe subtracts one. A strobe at 0 wraps the count to the top value and emits a borrow lasting one clock. Code 15 gives modulus 2^17.
- R5: A length change takes effect at once. The count keeps only the bits that fit the new length and continues counting from there.
- R6: On each I/D strobe the stage output toggles one clock later. A pending carry adds one extra toggle in the clock after that strobe. A pending borrow suppresses that strobe's toggle. A pending carry together with a pending borrow gives a plain toggle. I/D strobes must be at least two clocks apart.
- R7: The exclusive-OR detector output equals the XOR of its two inputs, one clock later.
- R8: The edge detector output goes to 1 one clock after a rising edge on its set input, and to 0 one clock after a rising edge on its clear input. If both edges arrive in the same clock, the output holds its value.
- R9: Reset clears the count, the pending pulses and all three outputs to 0.
- R10: In a closed loop using either detector, a divide-by-8 feedback and a 32-clock nominal period, the feedback settles to the reference frequency. This holds with length code 1 against a 34-clock reference, and with length code 15 against a 32-clock reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kclk_en | input | 1 | K-clock strobe; one counter step per strobe |
| idclk_en | input | 1 | I/D-clock strobe |
| cnt_en | input | 1 | Counter enable |
| count_down | input | 1 | Counter direction: 0 up, 1 down |
| len_sel | input | 4 | Counter length code (0 = disabled) |
| xr_ref | input | 1 | Exclusive-OR detector, reference input |
| xr_fb | input | 1 | Exclusive-OR detector, feedback input |
| ec_set | input | 1 | Edge detector set input (rising edge) |
| ec_clr | input | 1 | Edge detector clear input (rising edge) |
| xr_out | output | 1 | Exclusive-OR detector output |
| ec_out | output | 1 | Edge detector output |
| idc_out | output | 1 | Increment/decrement stage output |

## Verification
A counter state that is wrong for the selected length appears at the ports as a changed number of stage-output toggles. The extra or missing toggle shows up within two clocks of the next I/D strobe after the faulty wrap. The bench therefore counts toggles against strobes over each run and compares the surplus with the number of wraps computed from the length, direction and start value. A pending pulse that is lost or duplicated skews the same surplus. A detector fault is visible one clock after the input edge. In closed loop, a sign or modulus error shows up within tens of reference periods as a drift between the reference and feedback edge counts.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    localparam int DEF_SEL_W     = 4;
    localparam int DEF_STAGE_OFS = 2;

    typedef enum logic [1:0] {
        ID_PLAIN  = 2'd0,
        ID_INSERT = 2'd1,
        ID_DELETE = 2'd2
    } id_action_e;

    typedef struct packed {
        logic out;
        logic pend_up;
        logic pend_dn;
        logic extra;
    } idc_state_t;

    typedef struct packed {
        logic set_prev;
        logic clr_prev;
        logic out;
    } ec_state_t;

endpackage

// File: rtl/dpll_kcounter.sv
module dpll_kcounter
    import dpll_pkg::*;
#(
    parameter int SEL_W     = DEF_SEL_W,
    parameter int STAGE_OFS = DEF_STAGE_OFS,
    localparam int CW       = (1 << SEL_W) - 1 + STAGE_OFS,
    localparam int LW       = $clog2(CW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             cnt_en,
    input  logic             count_down,
    input  logic [SEL_W-1:0] len_sel,
    output logic             carry_o,
    output logic             borrow_o,
    output logic [CW-1:0]    count_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          carry;
        logic          borrow;
    } kst_t;

    kst_t          st_d, st_q;
    logic [LW-1:0] stages;
    logic [CW-1:0] mask;
    logic [CW-1:0] cur;
    logic          active;

    assign stages = LW'(len_sel) + LW'(STAGE_OFS);

    // one mask bit per stage, set for the stages the code enables
    generate
        for (genvar i = 0; i < CW; i++) begin : g_mask
            assign mask[i] = (stages > LW'(i));
        end
    endgenerate

    always_comb begin
        st_d        = st_q;
        st_d.carry  = 1'b0;
        st_d.borrow = 1'b0;
        active      = (len_sel != '0);
        cur         = active ? (st_q.cnt & mask) : st_q.cnt;
        st_d.cnt    = cur;
        if (active && cnt_en && step_en) begin
            if (!count_down) begin
                if (cur == mask) begin
                    st_d.cnt   = '0;
                    st_d.carry = 1'b1;
                end else begin
                    st_d.cnt = cur + CW'(1);
                end
            end else begin
                if (cur == '0) begin
                    st_d.cnt    = mask;
                    st_d.borrow = 1'b1;
                end else begin
                    st_d.cnt = cur - CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign carry_o  = st_q.carry;
    assign borrow_o = st_q.borrow;
    assign count_o  = st_q.cnt;

endmodule

// File: rtl/dpll_idstage.sv
module dpll_idstage
    import dpll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic carry_i,
    input  logic borrow_i,
    output logic out_o
);

    idc_state_t st_d, st_q;
    id_action_e act;
    logic       up, dn, tog;

    always_comb begin
        st_d         = st_q;
        up           = st_q.pend_up | carry_i;
        dn           = st_q.pend_dn | borrow_i;
        act          = ID_PLAIN;
        tog          = st_q.extra;
        st_d.extra   = 1'b0;
        st_d.pend_up = up;
        st_d.pend_dn = dn;
        if (tick) begin
            st_d.pend_up = 1'b0;
            st_d.pend_dn = 1'b0;
            case ({up, dn})
                2'b10:   act = ID_INSERT;
                2'b01:   act = ID_DELETE;
                default: act = ID_PLAIN;
            endcase
            case (act)
                ID_INSERT: begin
                    tog        = ~tog;
                    st_d.extra = 1'b1;
                end
                ID_DELETE: tog = tog;
                default:   tog = ~tog;
            endcase
        end
        st_d.out = st_q.out ^ tog;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_o = st_q.out;

endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det
    import dpll_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xa,
    input  logic xb,
    input  logic es,
    input  logic ec,
    output logic x_out,
    output logic e_out
);

    logic      x_d, x_q;
    ec_state_t e_d, e_q;
    logic      rise_s, rise_c;

    always_comb begin
        x_d        = xa ^ xb;
        e_d        = e_q;
        rise_s     = es & ~e_q.set_prev;
        rise_c     = ec & ~e_q.clr_prev;
        e_d.set_prev = es;
        e_d.clr_prev = ec;
        if (rise_s && !rise_c)      e_d.out = 1'b1;
        else if (rise_c && !rise_s) e_d.out = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= 1'b0;
            e_q <= '0;
        end else begin
            x_q <= x_d;
            e_q <= e_d;
        end
    end

    assign x_out = x_q;
    assign e_out = e_q.out;

endmodule

// File: rtl/dpll_core.sv
module dpll_core
    import dpll_pkg::*;
#(
    parameter int SEL_W     = DEF_SEL_W,
    parameter int STAGE_OFS = DEF_STAGE_OFS,
    localparam int CW       = (1 << SEL_W) - 1 + STAGE_OFS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             kclk_en,
    input  logic             idclk_en,
    input  logic             cnt_en,
    input  logic             count_down,
    input  logic [SEL_W-1:0] len_sel,
    input  logic             xr_ref,
    input  logic             xr_fb,
    input  logic             ec_set,
    input  logic             ec_clr,
    output logic             xr_out,
    output logic             ec_out,
    output logic             idc_out
);

    logic          carry_w, borrow_w;
    logic [CW-1:0] cnt_w;

    dpll_kcounter #(.SEL_W(SEL_W), .STAGE_OFS(STAGE_OFS)) u_kcnt (
        .clk       (clk),
        .rst       (rst),
        .step_en   (kclk_en),
        .cnt_en    (cnt_en),
        .count_down(count_down),
        .len_sel   (len_sel),
        .carry_o   (carry_w),
        .borrow_o  (borrow_w),
        .count_o   (cnt_w)
    );

    dpll_idstage u_ids (
        .clk     (clk),
        .rst     (rst),
        .tick    (idclk_en),
        .carry_i (carry_w),
        .borrow_i(borrow_w),
        .out_o   (idc_out)
    );

    dpll_phase_det u_pd (
        .clk  (clk),
        .rst  (rst),
        .xa   (xr_ref),
        .xb   (xr_fb),
        .es   (ec_set),
        .ec   (ec_clr),
        .x_out(xr_out),
        .e_out(ec_out)
    );

endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
    parameter int SEL_W     = 4,
    parameter int STAGE_OFS = 2,
    parameter int CW        = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             cnt_en,
    input logic             idclk_en,
    input logic [SEL_W-1:0] len_sel,
    input logic             ec_set,
    input logic             ec_clr,
    input logic             ec_out,
    input logic             idc_out,
    input logic             carry_w,
    input logic             borrow_w,
    input logic [CW-1:0]    cnt_w
);

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (len_sel == '0) |=> !(carry_w || borrow_w));

    assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && len_sel == $past(len_sel)) |=> $stable(cnt_w));

    assert_single_carry_R3: assert property (@(posedge clk) disable iff (rst)
        carry_w |=> !carry_w);

    assert_no_both_R4: assert property (@(posedge clk) disable iff (rst)
        !(carry_w && borrow_w));

    assert_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (len_sel != '0) |=> ((cnt_w >> ($past(len_sel) + STAGE_OFS)) == '0));

    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
        idclk_en |=> !idclk_en);

    assert_id_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(idclk_en) && !$past(idclk_en, 2)) |-> $stable(idc_out));

    assert_ec_set_R8: assert property (@(posedge clk) disable iff (rst)
        (ec_set && !$past(ec_set) && !(ec_clr && !$past(ec_clr))) |=> ec_out);

    assert_ec_clr_R8: assert property (@(posedge clk) disable iff (rst)
        (ec_clr && !$past(ec_clr) && !(ec_set && !$past(ec_set))) |=> !ec_out);

endmodule

bind dpll_core dpll_core_chk #(.SEL_W(SEL_W), .STAGE_OFS(STAGE_OFS), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .idclk_en(idclk_en),
    .len_sel (len_sel),
    .ec_set  (ec_set),
    .ec_clr  (ec_clr),
    .ec_out  (ec_out),
    .idc_out (idc_out),
    .carry_w (carry_w),
    .borrow_w(borrow_w),
    .cnt_w   (cnt_w)
);

// File: tb/dpll_core_test.sv
`timescale 1ns/1ps
module dpll_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       kclk_en = 1'b0, idclk_en = 1'b0, cnt_en = 1'b0, count_down = 1'b0;
    logic [3:0] len_sel = 4'd0;
    logic       xr_ref = 1'b0, xr_fb = 1'b0, ec_set = 1'b0, ec_clr = 1'b0;
    logic       xr_out, ec_out, idc_out;

    always #4 clk = ~clk;

    dpll_core uut (
        .clk(clk), .rst(rst), .kclk_en(kclk_en), .idclk_en(idclk_en),
        .cnt_en(cnt_en), .count_down(count_down), .len_sel(len_sel),
        .xr_ref(xr_ref), .xr_fb(xr_fb), .ec_set(ec_set), .ec_clr(ec_clr),
        .xr_out(xr_out), .ec_out(ec_out), .idc_out(idc_out)
    );

    // requests written by the tasks, applied by the driver process
    logic       rst_req = 1'b1, en_cfg = 1'b0, dn_cfg = 1'b0;
    logic [3:0] sel_cfg = 4'd0;
    logic       pa = 1'b0, pb = 1'b0, loop_on = 1'b0, use_ec = 1'b0;
    int         k_left = 0, ref_half = 17;

    // bench-side loop and counters
    logic id_seen = 1'b0, idt_phase = 1'b0, ref_sig = 1'b0, fb_sig = 1'b0;
    int   n_ticks = 0, n_togs = 0, ref_cnt = 0, fb_div = 0, ref_rises = 0, fb_rises = 0;

    typedef struct { string req; int val; int tol; } exp_t;
    exp_t exp_q[$];
    int   act_q[$];
    int   n_cmp = 0, n_bad = 0;
    bit   finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (idclk_en) n_ticks++;
            if (idc_out != id_seen) n_togs++;
            if (idc_out && !id_seen) begin
                fb_div++;
                if (fb_div == 4) begin
                    fb_div = 0;
                    fb_sig = !fb_sig;
                    if (fb_sig) fb_rises++;
                end
            end
            ref_cnt++;
            if (ref_cnt == ref_half) begin
                ref_cnt = 0;
                ref_sig = !ref_sig;
                if (ref_sig) ref_rises++;
            end
        end else begin
            n_ticks = 0; n_togs = 0; ref_cnt = 0; fb_div = 0;
            ref_sig = 1'b0; fb_sig = 1'b0;
        end
        id_seen   = idc_out;
        rst       = rst_req;
        idt_phase = !idt_phase;
        idclk_en  = idt_phase;
        cnt_en    = en_cfg;
        len_sel   = sel_cfg;
        if (loop_on) begin
            kclk_en    = 1'b1;
            count_down = use_ec ? ec_out : xr_out;
            xr_ref = ref_sig; xr_fb = fb_sig;
            ec_set = fb_sig;  ec_clr = ref_sig;
        end else begin
            kclk_en = (k_left > 0);
            if (k_left > 0) k_left--;
            count_down = dn_cfg;
            xr_ref = pa; xr_fb = pb;
            ec_set = pa; ec_clr = pb;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t e;
            int   a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_cmp++;
            if (a < e.val - e.tol || a > e.val + e.tol) begin
                n_bad++;
                $display("FAIL %s: actual %0d expected %0d (tol %0d)", e.req, a, e.val, e.tol);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_val(input string req, input int v, input int tol);
        exp_t e;
        e.req = req; e.val = v; e.tol = tol;
        exp_q.push_back(e);
    endtask

    task automatic do_reset();
        loop_on = 1'b0; k_left = 0; rst_req = 1'b1;
        step(3);
        rst_req = 1'b0;
        step(2);
    endtask

    // open-loop run: surplus of output toggles over I/D strobes
    task automatic run_surplus(input string req, input logic [3:0] sel, input logic dn,
                               input logic en, input int steps, input int exp_delta);
        do_reset();
        sel_cfg = sel; dn_cfg = dn; en_cfg = en;
        step(2);
        k_left = steps;
        step(steps + 30);
        expect_val(req, exp_delta, 0);
        act_q.push_back(n_togs - n_ticks);
    endtask

    task automatic run_lock(input string req, input logic [3:0] sel, input logic ec, input int half);
        int r0, f0;
        do_reset();
        ref_half = half; sel_cfg = sel; en_cfg = 1'b1; use_ec = ec; loop_on = 1'b1;
        step(8000);
        r0 = ref_rises; f0 = fb_rises;
        step(half * 200);
        expect_val(req, 0, 2);
        act_q.push_back((fb_rises - f0) - (ref_rises - r0));
        loop_on = 1'b0;
    endtask

    initial begin
        // R9: reset values
        rst_req = 1'b1;
        step(4);
        expect_val("R9 idc_out", 0, 0); act_q.push_back(int'(idc_out));
        expect_val("R9 xr_out", 0, 0);  act_q.push_back(int'(xr_out));
        expect_val("R9 ec_out", 0, 0);  act_q.push_back(int'(ec_out));

        run_surplus("R1 code0 no pulses", 4'd0, 1'b0, 1'b1, 50, 0);
        run_surplus("R2 enable low", 4'd1, 1'b0, 1'b0, 50, 0);
        run_surplus("R3 mod8 up carries", 4'd1, 1'b0, 1'b1, 20, 2);
        run_surplus("R3 mod16 up carries", 4'd2, 1'b0, 1'b1, 40, 2);
        run_surplus("R4 mod8 down borrows", 4'd1, 1'b1, 1'b1, 20, -3);
        run_surplus("R4 mod2^17 down wrap", 4'd15, 1'b1, 1'b1, 1, -1);
        run_surplus("R4 mod2^17 up no wrap", 4'd15, 1'b0, 1'b1, 300, 0);
        run_surplus("R6 plain toggling", 4'd1, 1'b0, 1'b1, 0, 0);

        // R5: count 10 at length 17, then code 1 keeps low bits (2); 6 steps wrap once
        do_reset();
        sel_cfg = 4'd15; dn_cfg = 1'b0; en_cfg = 1'b1;
        step(2);
        k_left = 10; step(15);
        sel_cfg = 4'd1; step(3);
        k_left = 6; step(36);
        expect_val("R5 length change", 1, 0);
        act_q.push_back(n_togs - n_ticks);

        // R7: exclusive-OR detector
        do_reset();
        pa = 1'b1; pb = 1'b0; step(3);
        expect_val("R7 xor 10", 1, 0); act_q.push_back(int'(xr_out));
        pb = 1'b1; step(3);
        expect_val("R7 xor 11", 0, 0); act_q.push_back(int'(xr_out));
        pa = 1'b0; step(3);
        expect_val("R7 xor 01", 1, 0); act_q.push_back(int'(xr_out));

        // R8: edge detector
        do_reset();
        pa = 1'b0; pb = 1'b0; step(3);
        pa = 1'b1; pb = 1'b1; step(3);
        expect_val("R8 both edges hold 0", 0, 0); act_q.push_back(int'(ec_out));
        pa = 1'b0; pb = 1'b0; step(3);
        pa = 1'b1; step(3);
        expect_val("R8 set edge", 1, 0); act_q.push_back(int'(ec_out));
        pa = 1'b0; step(3);
        expect_val("R8 no edge holds 1", 1, 0); act_q.push_back(int'(ec_out));
        pa = 1'b1; pb = 1'b1; step(3);
        expect_val("R8 both edges hold 1", 1, 0); act_q.push_back(int'(ec_out));
        pa = 1'b0; pb = 1'b0; step(3);
        pb = 1'b1; step(3);
        expect_val("R8 clear edge", 0, 0); act_q.push_back(int'(ec_out));
        pb = 1'b0; step(2);

        // R10: closed-loop lock
        run_lock("R10 lock xor code1", 4'd1, 1'b0, 17);
        run_lock("R10 lock edge code1", 4'd1, 1'b1, 17);
        run_lock("R10 lock xor code15", 4'd15, 1'b0, 16);
        run_lock("R10 lock edge code15", 4'd15, 1'b1, 16);

        step(4);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R10: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule